// File: doc/BRIEF.md
# Hashed Page Table Group Address Generator

This block holds the descriptor register that places a hashed page table in physical memory. It turns each translation request into the physical addresses of the two page-table groups that a later stage searches: a primary group and a secondary group. A write port loads the descriptor. At write time the descriptor is decoded into a table base and an index mask, so the request path does only an XOR, a shift and two AND-OR steps.

A mode input selects 32-bit or 64-bit behaviour. It selects the decode when the descriptor is written, and it selects the hash when a request is made. Each request returns both group addresses with a valid strobe one cycle later. A descriptor write that changes the stored value raises a one-cycle TLB flush pulse. In 64-bit mode, a write whose table-size field is out of range also raises a one-cycle clamp flag.

Top module: `htab_group_addr`

## Requirements
- R1: After reset the descriptor is zero, the decoded base is zero and the index mask is 0xFFFF. `tlb_flush`, `size_clamped` and `grp_valid` are low.
- R2: A 32-bit write (`mode_64`=0) sets the base to the written value ANDed with 0xFFFF0000. It sets the index mask to `{wdata[8:0], 16'hFFFF}`.
- R3: A 64-bit write sets the base to the written value ANDed with 0xFFFFFFFFFFFC0000. It sets the index mask to (1 << (size + 18)) - 1, where size is `wdata[4:0]`.
- R4: In a 64-bit write, a size field above 28 is treated as 28. `size_clamped` is high for exactly the cycle after such a write, and a size of 28 or less does not raise it.
- R5: In 32-bit mode the primary hash is ((`req_vsid[23:0]` XOR page index) << 6) AND 0x01FFFFC0. The page index is `req_ea[27:12]`.
- R6: In 64-bit mode the primary hash is ((`req_vsid` XOR page index) << 7) AND 0x00003FFFFFFFFF80, using the same page index.
- R7: The secondary hash is the bitwise complement of the primary hash ANDed with the same mode's VSID mask.
- R8: Each group address is base OR (hash AND index mask). It appears on `grp_pri` and `grp_sec` with `grp_valid` high in the cycle after `req_valid`, and `grp_valid` is low otherwise.
- R9: A write whose value differs from the stored descriptor pulses `tlb_flush` for one cycle. A write of the stored value raises no flush, no clamp flag and changes no later address.
- R10: A request made in the same cycle as a descriptor write uses the decode that was in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_64 | input | 1 | 1 selects 64-bit decode and hash, 0 selects 32-bit |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_wdata | input | 64 | Descriptor write value |
| req_valid | input | 1 | Translation request strobe |
| req_vsid | input | 64 | Segment VSID (low 24 bits used in 32-bit mode) |
| req_ea | input | 64 | Effective address of the request |
| grp_valid | output | 1 | Group addresses valid |
| grp_pri | output | 64 | Primary group physical address |
| grp_sec | output | 64 | Secondary group physical address |
| tlb_flush | output | 1 | One-cycle flush pulse after a changing write |
| size_clamped | output | 1 | One-cycle flag after a clamped 64-bit size |

## Verification
The bench builds the block with its default page shift of 12 and segment shift of 28. These defaults give a 16-bit page index, so effective-address bits both inside and outside the index field can be varied. With 64-bit descriptors and wide VSIDs, the test reaches the full 39-bit hash span and the 46-bit clamped mask. Stimulus covers both modes, HTABMASK at its extremes, sizes below, at and above the clamp, repeated identical writes, a write and a request in the same cycle, and back-to-back requests.

// File: rtl/htab_group_addr.sv
module htab_group_addr #(
  parameter int PAGE_SHIFT = 12,
  parameter int SEG_SHIFT  = 28,
  parameter int SIZE_MAX   = 28,
  parameter int SIZE_BIAS  = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_64,
  input  logic        cfg_we,
  input  logic [63:0] cfg_wdata,
  input  logic        req_valid,
  input  logic [63:0] req_vsid,
  input  logic [63:0] req_ea,
  output logic        grp_valid,
  output logic [63:0] grp_pri,
  output logic [63:0] grp_sec,
  output logic        tlb_flush,
  output logic        size_clamped
);

  localparam int          PIDX_W   = SEG_SHIFT - PAGE_SHIFT;
  localparam logic [63:0] VMASK32  = 64'h0000_0000_01FF_FFC0;
  localparam logic [63:0] VMASK64  = 64'h0000_3FFF_FFFF_FF80;
  localparam logic [63:0] BASE32   = 64'h0000_0000_FFFF_0000;
  localparam logic [63:0] BASE64   = ~((64'd1 << SIZE_BIAS) - 64'd1);
  localparam logic [4:0]  SZ_LIMIT = 5'(SIZE_MAX);
  localparam logic [5:0]  SZ_BIAS  = 6'(SIZE_BIAS);

  logic [63:0] desc_q, base_q, mask_q;

  logic        wr_change;
  logic [4:0]  sz_raw, sz_eff;
  logic        sz_over;
  logic [63:0] new_base, new_mask;

  assign wr_change = cfg_we && (cfg_wdata != desc_q);
  assign sz_raw    = cfg_wdata[4:0];
  assign sz_over   = sz_raw > SZ_LIMIT;
  assign sz_eff    = sz_over ? SZ_LIMIT : sz_raw;
  assign new_base  = cfg_wdata & (mode_64 ? BASE64 : BASE32);
  assign new_mask  = mode_64 ? ~({64{1'b1}} << ({1'b0, sz_eff} + SZ_BIAS))
                             : {39'd0, cfg_wdata[8:0], 16'hFFFF};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_q       <= '0;
      base_q       <= '0;
      mask_q       <= 64'h0000_0000_0000_FFFF;
      tlb_flush    <= 1'b0;
      size_clamped <= 1'b0;
    end else begin
      tlb_flush    <= wr_change;
      size_clamped <= wr_change && mode_64 && sz_over;
      if (wr_change) begin
        desc_q <= cfg_wdata;
        base_q <= new_base;
        mask_q <= new_mask;
      end
    end
  end

  logic [63:0] pidx, vsid_sel, vmask, hash_pri, hash_sec;

  assign pidx     = {{(64-PIDX_W){1'b0}}, req_ea[SEG_SHIFT-1:PAGE_SHIFT]};
  assign vsid_sel = mode_64 ? req_vsid : {40'd0, req_vsid[23:0]};
  assign vmask    = mode_64 ? VMASK64 : VMASK32;
  assign hash_pri = ((vsid_sel ^ pidx) << (mode_64 ? 7 : 6)) & vmask;
  assign hash_sec = ~hash_pri & vmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid <= 1'b0;
      grp_pri   <= '0;
      grp_sec   <= '0;
    end else begin
      grp_valid <= req_valid;
      if (req_valid) begin
        grp_pri <= base_q | (hash_pri & mask_q);
        grp_sec <= base_q | (hash_sec & mask_q);
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> grp_valid); // R8
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !grp_valid); // R8
  AST_GROUP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (grp_pri[5:0] == 6'd0 && grp_sec[5:0] == 6'd0)); // R8
  AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(cfg_we)); // R9
  AST_SAME_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata == desc_q) |=> (!tlb_flush && $stable(mask_q) && $stable(base_q))); // R9
  AST_CLAMP_64_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    size_clamped |-> ($past(mode_64) && tlb_flush)); // R4

endmodule

// File: tb/htab_group_addr_tb_top.sv
module htab_group_addr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_64 = 1'b0, cfg_we = 1'b0, req_valid = 1'b0;
  logic [63:0] cfg_wdata = '0, req_vsid = '0, req_ea = '0;
  logic grp_valid, tlb_flush, size_clamped;
  logic [63:0] grp_pri, grp_sec;

  always #(CLK_PERIOD/2) clk = ~clk;

  htab_group_addr dut_i (
    .clk(clk), .rst_n(rst_n), .mode_64(mode_64), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_vsid(req_vsid),
    .req_ea(req_ea), .grp_valid(grp_valid), .grp_pri(grp_pri),
    .grp_sec(grp_sec), .tlb_flush(tlb_flush), .size_clamped(size_clamped)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [63:0] pri; logic [63:0] sec; string tag; } exp_t;
  exp_t sb[$];

  logic [63:0] m_desc = '0, m_base = '0, m_mask = 64'hFFFF;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t expect_grp(logic [63:0] vsid, logic [63:0] ea, bit m64, string tag);
    logic [63:0] p, v, vm, h, hs;
    exp_t e;
    p  = {48'd0, ea[27:12]};
    if (m64) begin v = vsid; vm = 64'h3FFF_FFFF_FF80; h = ((v ^ p) << 7) & vm; end
    else begin v = {40'd0, vsid[23:0]}; vm = 64'h01FF_FFC0; h = ((v ^ p) << 6) & vm; end
    hs = ~h & vm;
    e.pri = m_base | (h & m_mask);
    e.sec = m_base | (hs & m_mask);
    e.tag = tag;
    return e;
  endfunction

  task automatic model_write(logic [63:0] d, bit m64, output bit fl, output bit cl);
    logic [4:0] sz;
    fl = (d != m_desc);
    sz = d[4:0];
    cl = fl && m64 && (sz > 5'd28);
    if (fl) begin
      m_desc = d;
      if (m64) begin
        if (sz > 5'd28) sz = 5'd28;
        m_base = d & 64'hFFFF_FFFF_FFFC_0000;
        m_mask = (64'd1 << (sz + 6'd18)) - 64'd1;
      end else begin
        m_base = d & 64'hFFFF_0000;
        m_mask = {39'd0, d[8:0], 16'hFFFF};
      end
    end
  endtask

  task automatic wr(logic [63:0] d, bit m64, string tag);
    bit fl, cl;
    @(negedge clk);
    cfg_we = 1; cfg_wdata = d; mode_64 = m64;
    model_write(d, m64, fl, cl);
    @(negedge clk);
    cfg_we = 0;
    chk(tlb_flush == fl, {tag, " flush"}, 64'(tlb_flush), 64'(fl));
    chk(size_clamped == cl, {tag, " clamp"}, 64'(size_clamped), 64'(cl));
  endtask

  task automatic rq(logic [63:0] vsid, logic [63:0] ea, bit m64, string tag);
    @(negedge clk);
    req_valid = 1; req_vsid = vsid; req_ea = ea; mode_64 = m64;
    sb.push_back(expect_grp(vsid, ea, m64, tag));
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && grp_valid) begin
      if (sb.size() == 0) chk(0, "R8 unexpected valid", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(grp_pri == e.pri, {e.tag, " primary"}, grp_pri, e.pri);
        chk(grp_sec == e.sec, {e.tag, " secondary"}, grp_sec, e.sec);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(tlb_flush == 0, "R1 flush", 64'(tlb_flush), 0);
    chk(size_clamped == 0, "R1 clamp", 64'(size_clamped), 0);
    chk(grp_valid == 0, "R1 valid", 64'(grp_valid), 0);
    rq(64'hFF12_3456, 64'h0ABC_D000, 0, "R1 reset decode");
    rq(64'h0000_0000, 64'hF000_0FFF, 0, "R5 zero index");

    wr(64'h1234_0003, 0, "R2 write");
    rq(64'h0012_3456, 64'h0ABC_D000, 0, "R5 hash32");
    rq(64'hABFF_FFFF, 64'h3FFF_F123, 0, "R7 sec32");
    wr(64'hABCD_01FF, 0, "R2 full mask");
    rq(64'h0055_AA55, 64'h0123_4000, 0, "R2 wide mask");
    wr(64'hABCD_01FF, 0, "R9 same write");
    rq(64'h0055_AA55, 64'h0123_4000, 0, "R9 unchanged");

    wr(64'h0000_0012_345C_0005, 1, "R3 write64");
    rq(64'h0000_0012_3456_789A, 64'h0000_0000_0FED_C000, 1, "R6 hash64");
    rq(64'h0000_007F_FFFF_FFFF, 64'h0000_0000_0000_0000, 1, "R7 sec64");
    wr(64'h0000_4000_0000_001F, 1, "R4 clamp31");
    rq(64'h0000_007F_FFFF_FFFF, 64'h0000_0000_0FFF_F000, 1, "R4 mask46");
    wr(64'h0000_4000_0000_001F, 1, "R9 same clamp");
    wr(64'h0000_4000_0000_001C, 1, "R4 size28");
    rq(64'h0000_0055_5555_5555, 64'h0000_0000_0AAA_A000, 1, "R4 size28 req");
    wr(64'h0000_4000_0000_001D, 1, "R4 size29");

    @(negedge clk);
    cfg_we = 1; cfg_wdata = 64'h8765_0001; mode_64 = 0;
    req_valid = 1; req_vsid = 64'h0034_5678; req_ea = 64'h0555_5000;
    sb.push_back(expect_grp(req_vsid, req_ea, 0, "R10 same cycle"));
    begin bit fl, cl; model_write(64'h8765_0001, 0, fl, cl); end
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    chk(tlb_flush == 1, "R10 flush", 64'(tlb_flush), 1);
    rq(64'h0034_5678, 64'h0555_5000, 0, "R10 after");

    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      req_valid = 1; mode_64 = 0;
      req_vsid = 64'h0011_1111 * (i + 1); req_ea = 64'h0123_0000 << i;
      sb.push_back(expect_grp(req_vsid, req_ea, 0, "R8 burst"));
      @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk(grp_valid == 0, "R8 idle valid", 64'(grp_valid), 0);
    chk(sb.size() == 0, "R8 all results", 64'(sb.size()), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule